// File: doc/BRIEF.md
# Two-Mode Priority Interrupt Control Register

This block is an eight-bit interrupt control and status register together with the logic that sets its flags and forms interrupt requests. Three sources feed it:
- a one-cycle timer overflow pulse;
- a one-cycle external edge pulse from an edge detector outside the block;
- any change on a four-pin group of an input port.

Each source has its own enable bit and its own flag bit. Two further bits act as global gates. An external mode input decides what those two bits mean.

In flat mode, the top bit gates every request, and the block drives a single request on the high output. In priority mode, a per-source priority input sends each source either to the high-priority output or to the low-priority output. The top bit gates the high output and the next bit gates the low output.

A flag latches whenever its event occurs, whatever the enables are, so software can poll the flags. The port-change flag compares the synchronised pins against a copy taken at the last port read. The CPU reads the register through a plain combinational read port and writes the whole byte with a write strobe. There is no streaming data path, so every pin is a plain control or status pin and there is no back-pressure.

Top module: `irq_ctl_reg`

## Requirements
- R1: After reset the register reads 0x00 (the port-change flag reset value is the parameter PCF_INIT, default 0), and both request outputs are low.
- R2: Bit layout, MSB to LSB: bit 7 high/global gate, bit 6 low/peripheral gate, bit 5 timer enable, bit 4 external enable, bit 3 port-change enable, bit 2 timer flag, bit 1 external flag, bit 0 port-change flag. A write stores the whole byte and it reads back on the next cycle when no event occurs.
- R3: A timer pulse sets bit 2 and an external pulse sets bit 1 at the next clock edge, even with every enable and gate bit clear.
- R4: A flag stays set until a CPU write of 0 to it. Hardware never clears a flag.
- R5: When hardware sets a flag in the same cycle as a CPU write of 0 to that flag, the flag ends up set.
- R6: The port-change flag sets when any of the four pins differs from the value captured at the last port read. A pin change driven before clock edge k is seen at edge k+2 (two synchroniser stages), and the flag reads 1 after that edge.
- R7: A port-read strobe loads the synchronised pins into the compare copy and does not clear the port-change flag. After the read, a CPU clear of the flag holds while the pins stay steady.
- R8: With the mode input low (flat), irq_hi_o = bit7 AND OR over sources of (flag AND enable), and irq_lo_o = 0. Bit 6 and src_prio_i have no effect on either output.
- R9: With the mode input high (priority), each source whose flag and enable are set goes to irq_hi_o when its src_prio_i bit is 1, gated by bit 7, and to irq_lo_o when that bit is 0, gated by bit 6. src_prio_i bit 0 is port change, bit 1 is external, bit 2 is timer.
- R10: The request outputs are combinational from register state, the mode input and src_prio_i, with no added register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prio_mode_i | input | 1 | 1 = priority mode, 0 = flat mode |
| src_prio_i | input | 3 | Per-source priority, 1 = high (bit 0 port change, bit 1 external, bit 2 timer) |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| ext_edge_i | input | 1 | External edge pulse |
| port_pins_i | input | 4 | Asynchronous port pins that are watched for change |
| port_rd_i | input | 1 | Port-read strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_hi_o | output | 1 | High-priority (or flat) interrupt request |
| irq_lo_o | output | 1 | Low-priority interrupt request |

## Verification
- **Lost enable or gate bit:** this shows on the request outputs in the same cycle the register changes, because those outputs are combinational from the register.
- **Lost flag update:** a flag that is missed, or cleared by hardware, shows in the register readback one clock after the event or after the write that races it.
- **Stale compare copy:** this shows as a port-change flag that does not set three edges after a pin change. It also shows as a flag that comes back after a CPU clear with the pins steady.
- **Wrong routing:** a fault in the routing shows as a request on the wrong output when the mode or a per-source priority bit is toggled.

// File: rtl/irq_ctl_pkg.sv
`timescale 1ns/1ps
package irq_ctl_pkg;
  localparam int NUM_SRC = 3;
  localparam int REG_W   = 8;
  // Source indices, shared by flag, enable and priority vectors.
  localparam int SRC_PORT = 0;
  localparam int SRC_EXT  = 1;
  localparam int SRC_TMR  = 2;

  // Packed MSB first: gate_hi is bit 7, flg[0] is bit 0.
  typedef struct packed {
    logic               gate_hi;
    logic               gate_lo;
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] flg;
  } ctl_reg_t;
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank
  import irq_ctl_pkg::*;
#(
  parameter int   PORT_W   = 4,
  parameter logic PCF_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_ovf_i,
  input  logic              ext_edge_i,
  input  logic [PORT_W-1:0] pins_sync_i,
  input  logic              port_rd_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output ctl_reg_t          reg_o
);
  localparam logic [REG_W-1:0] RST_VAL = {{(REG_W-1){1'b0}}, PCF_INIT};

  ctl_reg_t           reg_q, reg_d;
  logic [PORT_W-1:0]  pin_seen_q;
  logic [NUM_SRC-1:0] hw_set;

  always_comb begin
    hw_set           = '0;
    hw_set[SRC_TMR]  = tmr_ovf_i;
    hw_set[SRC_EXT]  = ext_edge_i;
    hw_set[SRC_PORT] = |(pins_sync_i ^ pin_seen_q);
  end

  // CPU write first, hardware set ORed on top so a racing event survives.
  always_comb begin
    reg_d = reg_q;
    if (we_i) reg_d = ctl_reg_t'(wdata_i);
    reg_d.flg = reg_d.flg | hw_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q      <= ctl_reg_t'(RST_VAL);
      pin_seen_q <= '0;
    end else begin
      reg_q <= reg_d;
      if (port_rd_i) pin_seen_q <= pins_sync_i;
    end
  end

  assign reg_o = reg_q;
endmodule

// File: rtl/irq_route.sv
`timescale 1ns/1ps
module irq_route
  import irq_ctl_pkg::*;
(
  input  ctl_reg_t           reg_i,
  input  logic               prio_mode_i,
  input  logic [NUM_SRC-1:0] src_prio_i,
  output logic               irq_hi_o,
  output logic               irq_lo_o
);
  logic [NUM_SRC-1:0] pend, to_hi, to_lo;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign pend[s]  = reg_i.flg[s] & reg_i.en[s];
    assign to_hi[s] = pend[s] & (!prio_mode_i | src_prio_i[s]);
    assign to_lo[s] = pend[s] & prio_mode_i & !src_prio_i[s];
  end

  assign irq_hi_o = reg_i.gate_hi & (|to_hi);
  assign irq_lo_o = reg_i.gate_lo & (|to_lo);
endmodule

// File: rtl/irq_ctl_reg.sv
`timescale 1ns/1ps
module irq_ctl_reg
  import irq_ctl_pkg::*;
#(
  parameter int   PORT_W      = 4,
  parameter int   SYNC_STAGES = 2,
  parameter logic PCF_INIT    = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prio_mode_i,
  input  logic [NUM_SRC-1:0] src_prio_i,
  input  logic               tmr_ovf_i,
  input  logic               ext_edge_i,
  input  logic [PORT_W-1:0]  port_pins_i,
  input  logic               port_rd_i,
  input  logic               reg_we_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               irq_hi_o,
  output logic               irq_lo_o
);
  logic [PORT_W-1:0] pins_sync;
  ctl_reg_t          ctl;

  irq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (port_pins_i),
    .q_o   (pins_sync)
  );

  irq_flag_bank #(.PORT_W(PORT_W), .PCF_INIT(PCF_INIT)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_ovf_i   (tmr_ovf_i),
    .ext_edge_i  (ext_edge_i),
    .pins_sync_i (pins_sync),
    .port_rd_i   (port_rd_i),
    .we_i        (reg_we_i),
    .wdata_i     (reg_wdata_i),
    .reg_o       (ctl)
  );

  irq_route u_route (
    .reg_i       (ctl),
    .prio_mode_i (prio_mode_i),
    .src_prio_i  (src_prio_i),
    .irq_hi_o    (irq_hi_o),
    .irq_lo_o    (irq_lo_o)
  );

  assign reg_rdata_o = REG_W'(ctl);
endmodule

// File: rtl/irq_ctl_chk.sv
`timescale 1ns/1ps
module irq_ctl_chk
  import irq_ctl_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               prio_mode_i,
  input logic [NUM_SRC-1:0] src_prio_i,
  input logic               tmr_ovf_i,
  input logic               ext_edge_i,
  input logic               reg_we_i,
  input logic [REG_W-1:0]   reg_wdata_i,
  input logic [REG_W-1:0]   reg_rdata_o,
  input logic               irq_hi_o,
  input logic               irq_lo_o
);
  // R2: enable and gate bits take the written value.
  a_r2_enables_written: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we_i) |-> reg_rdata_o[7:3] == $past(reg_wdata_i[7:3]));

  // R4: with no write, no flag goes from 1 to 0.
  a_r4_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we_i) |-> ($past(reg_rdata_o[2:0]) & ~reg_rdata_o[2:0]) == 3'b000);

  // R5: a timer event always leaves its flag set, even against a write.
  a_r5_tmr_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tmr_ovf_i) |-> reg_rdata_o[2]);

  // R5: same for the external event.
  a_r5_ext_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ext_edge_i) |-> reg_rdata_o[1]);

  // R8: flat mode never drives the low output.
  a_r8_flat_no_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_mode_i |-> !irq_lo_o);

  // R8: bit 7 gates the flat request.
  a_r8_flat_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!prio_mode_i && !reg_rdata_o[7]) |-> !irq_hi_o);

  // R9: bit 6 gates the low output in priority mode.
  a_r9_lo_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_mode_i && !reg_rdata_o[6]) |-> !irq_lo_o);

  // R9: a source marked high never reaches the low output.
  a_r9_hi_srcs_off_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_mode_i && (&src_prio_i)) |-> !irq_lo_o);
endmodule

bind irq_ctl_reg irq_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prio_mode_i (prio_mode_i),
  .src_prio_i  (src_prio_i),
  .tmr_ovf_i   (tmr_ovf_i),
  .ext_edge_i  (ext_edge_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_hi_o    (irq_hi_o),
  .irq_lo_o    (irq_lo_o)
);

// File: tb/irq_ctl_reg_tb.sv
`timescale 1ns/1ps
module irq_ctl_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prio_mode = 1'b0;
  logic [2:0] src_prio = 3'b000;
  logic       tmr = 1'b0, ext = 1'b0, prd = 1'b0, we = 1'b0;
  logic [3:0] pins = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       hi, lo;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_ctl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .prio_mode_i(prio_mode), .src_prio_i(src_prio),
    .tmr_ovf_i(tmr), .ext_edge_i(ext), .port_pins_i(pins), .port_rd_i(prd),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_hi_o(hi), .irq_lo_o(lo)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic pulse_tmr();
    @(negedge clk); tmr = 1'b1;
    @(negedge clk); tmr = 1'b0;
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext = 1'b1;
    @(negedge clk); ext = 1'b0;
  endtask

  task automatic port_read();
    @(negedge clk); prd = 1'b1;
    @(negedge clk); prd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset value", rdata, 8'h00);
    check("R1 reset hi", hi, 1'b0);
    check("R1 reset lo", lo, 1'b0);
  endtask

  task automatic t_readwrite();
    wr(8'hF8); check("R2 write enables", rdata, 8'hF8);
    wr(8'h07); check("R2 write flags", rdata, 8'h07);
    wr(8'h5A); check("R2 mixed pattern", rdata, 8'h5A);
    wr(8'h00); check("R2 clear all", rdata, 8'h00);
  endtask

  task automatic t_poll();
    pulse_tmr(); check("R3 timer flag no enables", rdata, 8'h04);
    check("R3 no request", {hi, lo}, 2'b00);
    pulse_ext(); check("R3 ext flag no enables", rdata, 8'h06);
    @(negedge clk); pins = 4'h8;
    @(negedge clk); @(negedge clk);
    check("R6 flag not yet after two edges", rdata, 8'h06);
    @(negedge clk);
    check("R6 port flag after three edges", rdata, 8'h07);
  endtask

  task automatic t_sticky();
    repeat (5) @(negedge clk);
    check("R4 flags held", rdata, 8'h07);
    port_read();
    check("R7 read keeps flag", rdata, 8'h07);
    wr(8'h00);
    check("R4 cleared by write", rdata, 8'h00);
    repeat (4) @(negedge clk);
    check("R7 steady pins no reset of flag", rdata, 8'h00);
    @(negedge clk); pins = 4'h9;
    repeat (3) @(negedge clk);
    check("R6 second change sets flag", rdata, 8'h01);
    port_read(); wr(8'h00);
    check("R7 clear after read", rdata, 8'h00);
  endtask

  task automatic t_set_wins();
    wr(8'h04);
    @(negedge clk); we = 1'b1; wdata = 8'h00; tmr = 1'b1;
    @(negedge clk); we = 1'b0; tmr = 1'b0;
    check("R5 timer set beats clear", rdata, 8'h04);
    @(negedge clk); we = 1'b1; wdata = 8'h00; ext = 1'b1;
    @(negedge clk); we = 1'b0; ext = 1'b0;
    check("R5 ext set beats clear", rdata, 8'h02);
    wr(8'h00);
  endtask

  task automatic t_flat();
    prio_mode = 1'b0; src_prio = 3'b000;
    wr(8'hA4); check("R8 flat request", {hi, lo}, 2'b10);
    src_prio = 3'b111; #1;
    check("R8 src_prio no effect", {hi, lo}, 2'b10);
    wr(8'h24); check("R8 bit7 gates", {hi, lo}, 2'b00);
    wr(8'h64); check("R8 bit6 no effect", {hi, lo}, 2'b00);
    wr(8'h84); check("R8 enable off", {hi, lo}, 2'b00);
    wr(8'h89); check("R8 port source flat", {hi, lo}, 2'b10);
  endtask

  task automatic t_prio();
    prio_mode = 1'b1; src_prio = 3'b100;
    wr(8'hA4); check("R9 timer high", {hi, lo}, 2'b10);
    wr(8'h24); check("R9 high gate off", {hi, lo}, 2'b00);
    src_prio = 3'b000;
    wr(8'h64); check("R9 timer low", {hi, lo}, 2'b01);
    wr(8'hA4); check("R9 low gate off", {hi, lo}, 2'b00);
    src_prio = 3'b010;
    wr(8'h92); check("R9 ext high", {hi, lo}, 2'b10);
    src_prio = 3'b110;
    wr(8'h49); check("R9 port low", {hi, lo}, 2'b01);
    src_prio = 3'b000;
    wr(8'hE4);
    @(negedge clk); prio_mode = 1'b0; #1;
    check("R10 mode switch same cycle", {hi, lo}, 2'b10);
    prio_mode = 1'b1; #1;
    check("R10 back to priority", {hi, lo}, 2'b01);
    src_prio = 3'b100; #1;
    check("R10 priority input same cycle", {hi, lo}, 2'b10);
    wr(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_readwrite();
    t_poll();
    t_sticky();
    t_set_wins();
    t_flat();
    t_prio();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule